// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash device. After software has written a program or erase command sequence, it hands the block one start pulse. The pulse carries the address to poll and either the byte just programmed or an erase flag. An erase flag means the finished array reads all-ones. The block then reads that address over and over through a one-outstanding read request/response port. It compares the top status bit with the bit the finished operation will present, and watches the time-limit bit of the status byte.

When the top bit turns true, the controller does not trust the rest of that byte, because the top bit can settle apart from the lower bits. It fetches one more byte and returns that byte as the result. If the time-limit bit is seen while the top bit still shows the complement, the block reads once more, because both bits can flip in the same read. That final read alone decides pass or fail. A read-count watchdog turns endless polling into a failure. The outcome is one `done` pulse, together with a pass flag and a result byte that hold steady until the next accepted start.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While and after reset, `busy`, `done` and `rd_req` are 0.
- R2: A start taken while idle captures `start_addr`, and every read request of that operation presents exactly that address on `rd_addr`.
- R3: The expected polling bit is `start_data[7]` for a program (`start_erase`=0) and 1 for an erase (`start_erase`=1). A read whose bit 7 equals it counts as completion.
- R4: After a completing read, exactly one further read is issued. Its full byte is reported on `result_data` with `pass`=1.
- R5: A read whose bit 7 differs from the expected bit and whose bit 5 is 0 leads to another read, as long as the watchdog has not run out.
- R6: A read whose bit 7 differs and whose bit 5 is 1 leads to exactly one re-read. If its bit 7 matches, the flow continues as in R4. Otherwise the result is `pass`=0 with that re-read byte on `result_data`.
- R7: If the MAX_READS-th polling read neither matches nor shows bit 5 = 1, the result is `pass`=0 with that read's byte on `result_data`.
- R8: A start pulse while `busy` is 1 is ignored and changes neither the polled address nor the outcome.
- R9: `done` is high for exactly one cycle per operation. `pass` and `result_data` change only with `done` and hold until the next outcome.
- R10: At most one read is outstanding. `rd_req` is a one-cycle pulse, and it is raised again only after the edge at which `rd_valid` was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_addr | input | AW | Address to poll |
| start_data | input | 8 | Byte that was programmed |
| start_erase | input | 1 | 1 = erase operation (expected byte all-ones) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 8 | Read response byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Outcome of the last operation |
| result_data | output | 8 | Byte reported with the outcome |

## Verification
The first `rd_req` is due one cycle after the edge that samples `start`. Each later request rises at the same edge that takes `rd_valid`. `done`, `pass` and `result_data` change one edge after the response that ends the operation. The bench drives inputs and samples outputs only on falling edges. It waits for `done` rather than counting cycles, then checks the outcome, the total read count and the address of every request against a model of the polling rules. The sweep covers every busy length and every time-limit position up to just past the watchdog limit, for both program and erase, with response latencies of one to three cycles.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  localparam int DATA_W   = 8;
  localparam int POLL_BIT = 7;
  localparam int TMO_BIT  = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrl_state_e;

  typedef enum logic [1:0] {
    PH_POLL  = 2'd0,
    PH_RECHK = 2'd1,
    PH_FINAL = 2'd2
  } poll_phase_e;

  typedef enum logic [2:0] {
    ACT_AGAIN = 3'd0,
    ACT_RECHK = 3'd1,
    ACT_FINAL = 3'd2,
    ACT_PASS  = 3'd3,
    ACT_FAIL  = 3'd4
  } poll_act_e;

endpackage

// File: rtl/flash_poll_wdog.sv
module flash_poll_wdog #(
  parameter int MAX_READS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic last
);
  localparam int CW = $clog2(MAX_READS + 1);
  localparam logic [CW-1:0] LIMIT_M1 = CW'(MAX_READS - 1);
  localparam logic [CW-1:0] LIMIT    = CW'(MAX_READS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // the read being judged now is the MAX_READS-th polling read
  assign last = (cnt_q == LIMIT_M1);

  // R7: polling never runs past the limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
  import flash_poll_pkg::*;
(
  input  poll_phase_e       phase,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              exp_bit,
  input  logic              wd_last,
  output poll_act_e         act
);
  logic hit;
  logic tmo;

  assign hit = (rd_data[POLL_BIT] == exp_bit);
  assign tmo = rd_data[TMO_BIT];

  always_comb begin
    act = ACT_FAIL;
    unique case (phase)
      PH_POLL: begin
        if (hit)          act = ACT_FINAL;
        else if (tmo)     act = ACT_RECHK;
        else if (wd_last) act = ACT_FAIL;
        else              act = ACT_AGAIN;
      end
      PH_RECHK: act = hit ? ACT_FINAL : ACT_FAIL;
      PH_FINAL: act = ACT_PASS;
      default:  act = ACT_FAIL;
    endcase
  end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int AW        = 19,
  parameter int MAX_READS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              start_erase,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [DATA_W-1:0] result_data
);

  ctrl_state_e       state_q;
  poll_phase_e       phase_q;
  logic              exp_q;
  logic [AW-1:0]     addr_q;
  logic              req_q;
  logic              done_q;
  logic              pass_q;
  logic [DATA_W-1:0] res_q;

  logic      accept;
  logic      take;
  logic      wd_tick;
  logic      wd_last;
  poll_act_e act;

  assign accept  = start && (state_q == ST_IDLE);
  assign take    = rd_valid && (state_q == ST_WAIT);
  assign wd_tick = take && (phase_q == PH_POLL);

  flash_poll_wdog #(
    .MAX_READS (MAX_READS)
  ) u_wdog (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .tick  (wd_tick),
    .last  (wd_last)
  );

  flash_poll_judge u_judge (
    .phase   (phase_q),
    .rd_data (rd_data),
    .exp_bit (exp_q),
    .wd_last (wd_last),
    .act     (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_POLL;
      exp_q   <= 1'b0;
      addr_q  <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= start_addr;
            exp_q   <= start_erase | start_data[POLL_BIT];
            phase_q <= PH_POLL;
            req_q   <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          req_q <= 1'b0;
          if (rd_valid) begin
            unique case (act)
              ACT_AGAIN: req_q <= 1'b1;
              ACT_RECHK: begin
                phase_q <= PH_RECHK;
                req_q   <= 1'b1;
              end
              ACT_FINAL: begin
                phase_q <= PH_FINAL;
                req_q   <= 1'b1;
              end
              ACT_PASS, ACT_FAIL: begin
                done_q  <= 1'b1;
                pass_q  <= (act == ACT_PASS);
                res_q   <= rd_data;
                state_q <= ST_IDLE;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req      = req_q;
  assign rd_addr     = addr_q;
  assign busy        = (state_q == ST_WAIT);
  assign done        = done_q;
  assign pass        = pass_q;
  assign result_data = res_q;

  // R10: no second request while one is still open
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    (req_q && !rd_valid) |=> !req_q);

  // R10: requests only while an operation runs
  a_r10_req_when_busy: assert property (@(posedge clk) disable iff (rst)
    req_q |-> busy);

  // R9: completion strobe lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R9: outcome moves only together with done
  a_r9_pass_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(pass_q) |-> done_q);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_q) |-> done_q);

  // R2, R8: polled address fixed for the whole operation
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(addr_q));

  // R4: a pass is only reported after the confirming read
  a_r4_pass_after_final: assert property (@(posedge clk) disable iff (rst)
    (done_q && pass_q) |-> $past(phase_q == PH_FINAL));

endmodule

// File: tb/tb_flash_poll_ctrl.sv
module tb_flash_poll_ctrl;
  localparam int AW  = 12;
  localparam int MAX = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    start_data = '0;
  logic          start_erase = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          busy, done, pass;
  logic [7:0]    result_data;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int            n_busy, t_tmo, lat, req_count, addr_bad;
  logic [7:0]    exp_byte;
  logic [AW-1:0] cur_addr;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .MAX_READS(MAX)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_data(start_data), .start_erase(start_erase),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .pass(pass), .result_data(result_data)
  );

  function automatic logic [7:0] model(input int i);
    logic [31:0] iv;
    iv = i;
    if (i < n_busy)       return {~exp_byte[7], iv[0], (i >= t_tmo), 5'h0A};
    else if (i == n_busy) return {exp_byte[7], ~exp_byte[6:0]};
    else                  return exp_byte;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (n=%0d t=%0d)", req, act, exp, n_busy, t_tmo);
    end
  endtask

  // flash-side responder
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        int ri;
        if (rd_addr !== cur_addr) addr_bad++;
        ri = req_count;
        req_count++;
        repeat (lat - 1) @(negedge clk);
        rd_data  = model(ri);
        rd_valid = 1'b1;
      end
    end
  end

  task automatic run(input bit erase, input logic [7:0] data, input int n, input int t, input int l);
    bit e_pass, fin, seen;
    logic [7:0] e_res;
    int e_reads;
    logic p_hold;
    logic [7:0] r_hold;
    int extra;
    n_busy = n; t_tmo = t; lat = l;
    req_count = 0; addr_bad = 0;
    cur_addr = AW'(n * 301 + t * 17 + (erase ? 7 : 3));
    exp_byte = erase ? 8'hFF : data;
    fin = 0; e_pass = 0; e_res = '0; e_reads = 0;
    for (int i = 0; i < 64; i++) begin
      if (!fin) begin
        if (i >= n) begin
          e_pass = 1; e_res = model(i + 1); e_reads = i + 2; fin = 1;
        end else if (i >= t) begin
          if (i + 1 >= n) begin e_pass = 1; e_res = model(i + 2); e_reads = i + 3; end
          else            begin e_pass = 0; e_res = model(i + 1); e_reads = i + 2; end
          fin = 1;
        end else if (i + 1 == MAX) begin
          e_pass = 0; e_res = model(i); e_reads = i + 1; fin = 1;
        end
      end
    end
    @(negedge clk);
    start = 1'b1; start_addr = cur_addr; start_data = data; start_erase = erase;
    @(negedge clk);
    // R8: second start while busy, with a different address and mode
    start = 1'b1; start_addr = ~cur_addr; start_data = ~data; start_erase = ~erase;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 400; k++) begin
      if (!seen) begin
        if (done) seen = 1;
        else @(negedge clk);
      end
    end
    check(seen, "R9 done seen", 32'(seen), 1);
    check(pass == e_pass, "R3/R5/R6/R7 pass", 32'(pass), 32'(e_pass));
    check(result_data == e_res, "R4/R6/R7 result_data", 32'(result_data), 32'(e_res));
    p_hold = pass; r_hold = result_data;
    extra = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R9 single-cycle done", 32'(extra), 0);
    check(pass == p_hold && result_data == r_hold && !busy, "R9 outcome held", {23'b0, pass, result_data}, {23'b0, p_hold, r_hold});
    check(req_count == e_reads, "R5/R8/R10 read count", 32'(req_count), 32'(e_reads));
    check(addr_bad == 0, "R2/R8 read address", 32'(addr_bad), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !rd_req, "R1 reset outputs", {29'b0, busy, done, rd_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !rd_req, "R1 idle after reset", {29'b0, busy, done, rd_req}, 0);
    for (int e = 0; e < 2; e++)
      for (int n = 0; n <= MAX + 1; n++)
        for (int ti = 0; ti <= MAX + 2; ti++) begin
          int t;
          t = (ti == MAX + 2) ? 99 : ti;
          run(e[0], 8'(n * 37 + ti * 11 + 5), n, t, 1 + ((n + ti) % 3));
        end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule